// File: doc/BRIEF.md
# Byte-Write Cycle and Output Controller

This block sits behind the address generator of a synchronous common-I/O memory port. On every clock it classifies the cycle from the two access strobes, the select status and the write controls. The possible kinds are deselect, new read, continued read, write or idle. It turns the write controls into four per-lane write strobes. A lane is 9 bits: 8 data bits and their parity bit. The strobes update a small internal register array on the same rising edge that qualifies the write.

Reads are flow-through. The address used at an edge is held, and the array word at that address is presented on `rd_data` for the whole following cycle. A separate enable, `bus_drive`, tells the pad logic when the shared data bus may be driven. This enable follows the active-low output enable without waiting for a clock. It is forced low during writes, while deselected, on the first cycle after leaving deselection, and after a write until a strobe starts a new read.

Top module: `byte_write_ctrl`

## Requirements
- R1: When `glob_wr_n` is low in a write cycle, all four write strobes are set, whatever `byte_en_n` and `lane_sel_n` are.
- R2: When `glob_wr_n` is high and `byte_en_n` is low, strobe i is set exactly when `lane_sel_n[i]` is low. Every one of the 16 select patterns is accepted.
- R3: When `glob_wr_n` and `byte_en_n` are both high, or when all four selects are high, the cycle is a read: no strobe is set and the array is unchanged.
- R4: A cycle with `proc_stb_n` low and `sel` high is a read whatever the write controls are. A write cycle may follow on the next clock as a continuation.
- R5: A cycle with `ctrl_stb_n` low, `proc_stb_n` high, `sel` high and write controls active writes `wr_data` into the array at `addr` on that same edge.
- R6: Lane i occupies bits [9i+8:9i], with its parity bit at 9i+8. All nine bits of a lane are written together, and only under that lane's strobe.
- R7: After a strobe-started read at address A from a selected state, `rd_data` equals the word at A in the next cycle, and `bus_drive` is high there when `out_en_n` is low.
- R8: In the first cycle after a read is started from the deselected state, `bus_drive` stays low regardless of `out_en_n`. In the cycle after that it follows `out_en_n` again.
- R9: `bus_drive` is low in any write cycle. After a write it stays low through continuation cycles until a strobe starts a new read.
- R10: A strobe with `sel` low deselects the port: no strobe is set, and nothing is written while the port stays deselected. `bus_drive` stays low throughout.
- R11: When the output is not forced off, `bus_drive` is the inverse of `out_en_n` within the same cycle, with no clock edge needed.
- R12: After reset the port is deselected, `bus_drive` is low, and no write strobe is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Word address from the address generator for this cycle |
| sel | input | 1 | High when all chip selects are active (used only when a strobe is low) |
| proc_stb_n | input | 1 | Processor access strobe, active low, has priority |
| ctrl_stb_n | input | 1 | Controller access strobe, active low |
| glob_wr_n | input | 1 | Write-all-lanes control, active low |
| byte_en_n | input | 1 | Per-lane write enable qualifier, active low |
| lane_sel_n | input | 4 | Per-lane selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | 36 | Write word, four 9-bit lanes |
| rd_data | output | 36 | Flow-through read word |
| bus_drive | output | 1 | Data bus drive enable |
| wr_strb | output | 4 | Per-lane write strobes of this cycle |

## Verification
The situation that is hardest to reach from the ports is the masked first cycle after deselection. The port must first be deselected by a strobe with `sel` low. Then write controls are held active while it idles, to show that nothing is written. A processor strobe then reopens the port, and the enable is sampled in the masked cycle and in the cycle after it. The byte-write rules are covered by a sweep over all 64 combinations of the three write controls. Each combination follows a full-word prefill and is followed by a read-back compared with a lane-merged expected word.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int NUM_LANES = 4;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_RD_NEW,
        OP_RD_CONT,
        OP_WR
    } op_e;

    typedef enum logic [1:0] {
        OS_DESEL,
        OS_MASK,
        OS_ON,
        OS_WRHOLD
    } ostate_e;

    typedef struct packed {
        logic                 want;
        logic [NUM_LANES-1:0] lanes;
    } wr_req_t;

    function automatic wr_req_t qualify_write(
        input logic                 glob_n,
        input logic                 ben_n,
        input logic [NUM_LANES-1:0] sel_n
    );
        wr_req_t r;
        if (!glob_n) begin
            r.lanes = '1;
        end else if (!ben_n) begin
            r.lanes = ~sel_n;
        end else begin
            r.lanes = '0;
        end
        r.want = |r.lanes;
        return r;
    endfunction

endpackage

// File: rtl/bwc_write_decode.sv
module bwc_write_decode
    import bwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 proc_stb_n,
    input  logic                 ctrl_stb_n,
    input  logic                 sel,
    input  logic                 active,
    input  logic                 glob_wr_n,
    input  logic                 byte_en_n,
    input  logic [NUM_LANES-1:0] lane_sel_n,
    output op_e                  op,
    output logic [NUM_LANES-1:0] wr_lanes
);

    wr_req_t req;
    logic    strobe;

    always_comb begin
        req    = qualify_write(glob_wr_n, byte_en_n, lane_sel_n);
        strobe = !proc_stb_n || !ctrl_stb_n;
        if (strobe) begin
            if (!sel) begin
                op = OP_DESEL;
            end else if (!proc_stb_n) begin
                op = OP_RD_NEW;
            end else if (req.want) begin
                op = OP_WR;
            end else begin
                op = OP_RD_NEW;
            end
        end else if (active) begin
            op = req.want ? OP_WR : OP_RD_CONT;
        end else begin
            op = OP_IDLE;
        end
        wr_lanes = (op == OP_WR) ? req.lanes : '0;
    end

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (!glob_wr_n && !ctrl_stb_n && proc_stb_n && sel) |-> (wr_lanes == '1)); // R1

    AST_LANE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        glob_wr_n |-> ((wr_lanes & lane_sel_n) == '0)); // R2

    AST_READ_NO_LANES: assert property (@(posedge clk) disable iff (rst)
        (glob_wr_n && byte_en_n) |-> (wr_lanes == '0)); // R3

endmodule

// File: rtl/bwc_out_ctrl.sv
module bwc_out_ctrl
    import bwc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic out_en_n,
    output logic active,
    output logic bus_drive
);

    ostate_e ostate;
    ostate_e ostate_nx;

    always_comb begin
        case (op)
            OP_DESEL:   ostate_nx = OS_DESEL;
            OP_RD_NEW:  ostate_nx = (ostate == OS_DESEL) ? OS_MASK : OS_ON;
            OP_RD_CONT: ostate_nx = (ostate == OS_WRHOLD) ? OS_WRHOLD : OS_ON;
            OP_WR:      ostate_nx = OS_WRHOLD;
            default:    ostate_nx = ostate;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ostate <= OS_DESEL;
        end else begin
            ostate <= ostate_nx;
        end
    end

    assign active    = (ostate != OS_DESEL);
    assign bus_drive = !out_en_n && (ostate == OS_ON) && (op != OP_WR);

    AST_MASK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ostate == OS_DESEL) |=> !bus_drive); // R8

    AST_HOLD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WR) |=> !bus_drive); // R9

endmodule

// File: rtl/bwc_lane_store.sv
module bwc_lane_store #(
    parameter  int LANE_W = 9,
    parameter  int DEPTH  = 16,
    localparam int NL     = bwc_pkg::NUM_LANES,
    localparam int AW     = $clog2(DEPTH),
    localparam int DW     = NL * LANE_W
) (
    input  logic          clk,
    input  logic [NL-1:0] we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/byte_write_ctrl.sv
module byte_write_ctrl
    import bwc_pkg::*;
#(
    parameter  int LANE_W = 9,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int DW     = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        addr,
    input  logic                 sel,
    input  logic                 proc_stb_n,
    input  logic                 ctrl_stb_n,
    input  logic                 glob_wr_n,
    input  logic                 byte_en_n,
    input  logic [NUM_LANES-1:0] lane_sel_n,
    input  logic                 out_en_n,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic                 bus_drive,
    output logic [NUM_LANES-1:0] wr_strb
);

    op_e           op;
    logic          active;
    logic [AW-1:0] raddr_q;

    bwc_write_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sel        (sel),
        .active     (active),
        .glob_wr_n  (glob_wr_n),
        .byte_en_n  (byte_en_n),
        .lane_sel_n (lane_sel_n),
        .op         (op),
        .wr_lanes   (wr_strb)
    );

    bwc_out_ctrl u_out (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .out_en_n  (out_en_n),
        .active    (active),
        .bus_drive (bus_drive)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            raddr_q <= '0;
        end else if (op == OP_RD_NEW || op == OP_RD_CONT || op == OP_WR) begin
            raddr_q <= addr;
        end
    end

    bwc_lane_store #(
        .LANE_W (LANE_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (wr_strb),
        .waddr (addr),
        .wdata (wr_data),
        .raddr (raddr_q),
        .rdata (rd_data)
    );

    AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        !proc_stb_n |-> (wr_strb == '0)); // R4

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!sel && (!proc_stb_n || !ctrl_stb_n)) |-> (wr_strb == '0)); // R10

    AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        (wr_strb != '0) |-> !bus_drive); // R9

    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !bus_drive); // R11

endmodule

// File: tb/tb_byte_write_ctrl.sv
module tb_byte_write_ctrl;

    localparam int LW    = 9;
    localparam int NL    = 4;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          sel;
    logic          proc_stb_n;
    logic          ctrl_stb_n;
    logic          glob_wr_n;
    logic          byte_en_n;
    logic [NL-1:0] lane_sel_n;
    logic          out_en_n;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          bus_drive;
    logic [NL-1:0] wr_strb;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] model [DEPTH];

    always #5 clk = ~clk;

    byte_write_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .sel        (sel),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .glob_wr_n  (glob_wr_n),
        .byte_en_n  (byte_en_n),
        .lane_sel_n (lane_sel_n),
        .out_en_n   (out_en_n),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .bus_drive  (bus_drive),
        .wr_strb    (wr_strb)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        logic [63:0] v;
        v = 64'h9E37_79B9_7F4A_7C15 * 64'(a * 131 + k * 7 + 1);
        return v[DW+3:4];
    endfunction

    function automatic logic [NL-1:0] exp_lanes(input logic g, input logic b, input logic [NL-1:0] s);
        if (!g) return '1;      // R1
        if (!b) return ~s;      // R2
        return '0;              // R3
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                            input logic [NL-1:0] ln);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NL; i++) begin
            if (ln[i]) r[i*LW +: LW] = new_w[i*LW +: LW];   // R6 lane = 9 bits
        end
        return r;
    endfunction

    task automatic idle();
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b1;
        glob_wr_n  = 1'b1;
        byte_en_n  = 1'b1;
        lane_sel_n = '1;
        sel        = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctrl_write(input int a, input logic [DW-1:0] d, input logic g, input logic b,
                              input logic [NL-1:0] s, input string tag);
        logic [NL-1:0] el;
        idle();
        ctrl_stb_n = 1'b0;
        addr       = AW'(a);
        wr_data    = d;
        glob_wr_n  = g;
        byte_en_n  = b;
        lane_sel_n = s;
        #1;
        el = exp_lanes(g, b, s);
        chk(wr_strb == el, {tag, " R5 strobes"}, 64'(wr_strb), 64'(el));
        if (el != '0) chk(bus_drive == 1'b0, "R9 drive off in write", 64'(bus_drive), 64'd0);
        tick();
        model[a] = merge(model[a], d, el);
        idle();
    endtask

    task automatic read_check(input int a, input string tag);
        idle();
        ctrl_stb_n = 1'b0;
        addr       = AW'(a);
        tick();
        idle();
        #1;
        chk(rd_data == model[a], {tag, " R6 R7 data"}, 64'(rd_data), 64'(model[a]));
        chk(bus_drive == 1'b1, "R7 drive on", 64'(bus_drive), 64'd1);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst      = 1'b1;
        out_en_n = 1'b0;
        addr     = '0;
        wr_data  = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        glob_wr_n = 1'b0;
        #1;
        chk(bus_drive == 1'b0, "R12 drive off after reset", 64'(bus_drive), 64'd0);
        chk(wr_strb == '0, "R12 no strobe while deselected", 64'(wr_strb), 64'd0);
        idle();

        // Initialise every word with a full write so reads have known contents
        for (int a = 0; a < DEPTH; a++) ctrl_write(a, pat(a, 99), 1'b0, 1'b1, 4'hF, "R1 init");

        // Sweep all 64 write-control combinations
        for (int code = 0; code < 64; code++) begin
            int    a;
            string tg;
            a = code % DEPTH;
            ctrl_write(a, pat(a, 0), 1'b0, 1'b1, 4'hF, "R1 prefill");
            if (code[5] == 1'b0)      tg = "R1";
            else if (code[4] == 1'b0) tg = "R2";
            else                      tg = "R3";
            ctrl_write(a, pat(a, code + 1), code[5], code[4], 4'(code), tg);
            read_check(a, tg);
        end

        // R4: processor strobe ignores write controls, write may follow
        ctrl_write(3, pat(3, 200), 1'b0, 1'b1, 4'hF, "R1 setup");
        read_check(3, "R4 setup");
        idle();
        proc_stb_n = 1'b0;
        glob_wr_n  = 1'b0;
        byte_en_n  = 1'b0;
        lane_sel_n = '0;
        addr       = 4'd3;
        wr_data    = ~model[3];
        #1;
        chk(wr_strb == '0, "R4 no strobe on processor strobe", 64'(wr_strb), 64'd0);
        tick();
        idle();
        #1;
        chk(rd_data == model[3], "R4 data unchanged", 64'(rd_data), 64'(model[3]));
        chk(bus_drive == 1'b1, "R4 read drives", 64'(bus_drive), 64'd1);
        tick();
        glob_wr_n = 1'b0;
        wr_data   = pat(3, 201);
        #1;
        chk(wr_strb == 4'hF, "R4 later write", 64'(wr_strb), 64'hF);
        chk(bus_drive == 1'b0, "R9 write forces off", 64'(bus_drive), 64'd0);
        tick();
        model[3] = pat(3, 201);
        idle();
        #1;
        chk(bus_drive == 1'b0, "R9 off after write", 64'(bus_drive), 64'd0);
        tick();
        #1;
        chk(bus_drive == 1'b0, "R9 still off on continuation", 64'(bus_drive), 64'd0);
        read_check(3, "R9 strobe reopens");

        // R11: enable follows out_en_n without a clock
        out_en_n = 1'b1;
        #1;
        chk(bus_drive == 1'b0, "R11 oe high", 64'(bus_drive), 64'd0);
        out_en_n = 1'b0;
        #1;
        chk(bus_drive == 1'b1, "R11 oe low", 64'(bus_drive), 64'd1);

        // R10 / R8: deselect, idle with write controls, then reopen
        @(negedge clk);
        idle();
        ctrl_stb_n = 1'b0;
        sel        = 1'b0;
        glob_wr_n  = 1'b0;
        addr       = 4'd5;
        wr_data    = ~model[5];
        #1;
        chk(wr_strb == '0, "R10 deselect strobe", 64'(wr_strb), 64'd0);
        tick();
        idle();
        glob_wr_n = 1'b0;
        #1;
        chk(wr_strb == '0, "R10 no write while deselected", 64'(wr_strb), 64'd0);
        chk(bus_drive == 1'b0, "R10 drive off deselected", 64'(bus_drive), 64'd0);
        tick();
        idle();
        proc_stb_n = 1'b1;
        proc_stb_n = 1'b0;
        addr       = 4'd5;
        tick();
        idle();
        #1;
        chk(bus_drive == 1'b0, "R8 first cycle masked", 64'(bus_drive), 64'd0);
        tick();
        #1;
        chk(bus_drive == 1'b1, "R8 second cycle drives", 64'(bus_drive), 64'd1);
        chk(rd_data == model[5], "R10 word untouched", 64'(rd_data), 64'(model[5]));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule